// File: doc/BRIEF.md
# Serial Programming Mode Entry Detector

This block sits on the target side of a two-wire serial programming port. It watches three pins: a reset/enable pin (`hold_pin`), a programming clock (`ser_clk`) and a programming data line (`ser_dat`). It decides whether the target may enter program/verify mode. All three pins are asynchronous to the system clock, so they pass through a synchronizer first. Rising edges of the programming clock are then detected in the system clock domain.

An entry attempt follows a fixed order:

1. A short high pulse arrives on the reset/enable pin.
2. A settling gap of `ENTRY_GAP` system clocks follows.
3. A 32-bit key is shifted in, most significant bit first.
4. The reset/enable pin rises and stays high.

If the key matches exactly, the block raises `mode_active` and `io_hiz`. It then waits `EXIT_GAP` system clocks before it treats any data bit as valid.

After that wait, each programming-clock rising edge produces a one-cycle `rx_valid` strobe carrying the sampled bit on `rx_bit`. This outgoing bit stream has no back-pressure. The source is a free-running pin, so there is no ready input, and every strobe is final. A fall of the reset/enable pin ends the mode at once and discards the partial key.

Top module: `pgm_entry_detect`

## Requirements
- R1: After system reset, `mode_active`, `io_hiz`, `data_open` and `rx_valid` are all 0.
- R2: A reset-pin pulse, then the key 0x4D434851 shifted in, then a reset-pin rise sets both `mode_active` and `io_hiz` to 1.
- R3: The key is taken most significant bit first. The same key sent least significant bit first does not enter the mode.
- R4: Any 32-bit value other than 0x4D434851 leaves `mode_active` at 0 after the reset-pin rise.
- R5: Key bits clocked in before any reset-pin pulse has been seen are not accepted, so the following rise does not enter the mode.
- R6: Programming-clock edges during the `ENTRY_GAP` cycles after the pulse falls are ignored and do not disturb the key.
- R7: A reset-pin rise before 32 key bits refuses entry and clears the key. That rise and its later fall count as a fresh pulse for a new attempt.
- R8: For `EXIT_GAP` cycles after the entering rise, programming-clock edges produce no `rx_valid`.
- R9: Once `data_open` is 1, each programming-clock rising edge yields exactly one `rx_valid` strobe, with the data-line level on `rx_bit`, in arrival order.
- R10: A fall of the reset/enable pin drops `mode_active`, `io_hiz` and `data_open`, and no further strobes follow.
- R11: Programming-clock edges after the 32nd key bit and before the reset-pin rise are ignored, and a correct key still enters.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low system reset |
| hold_pin | input | 1 | Reset/enable pin, asynchronous |
| ser_clk | input | 1 | Programming clock pin, asynchronous |
| ser_dat | input | 1 | Programming data pin, asynchronous |
| mode_active | output | 1 | Program/verify mode is held |
| io_hiz | output | 1 | Request to tristate unused I/O |
| data_open | output | 1 | Blanking has ended and data bits are forwarded |
| rx_valid | output | 1 | One-cycle strobe for a forwarded data bit |
| rx_bit | output | 1 | Data bit sampled at the programming-clock rise |

## Verification
A wrong sequencer state shows up in one of two ways. Either `mode_active` rises after a refused attempt, or it stays low after a good one. The bench sees this a few cycles after the reset-pin rise: two synchronizer stages, one edge-detect register and the state register. A key register that was not cleared, or that shifted in the wrong direction, only becomes visible at that same rise, so each refusal case is followed by a correct attempt. A blanking counter that is off in either direction shows up as early or missing `rx_valid` strobes. The scoreboard flags these on the first programming-clock edge that should or should not have been forwarded.

// File: rtl/pgm_entry_pkg.sv
package pgm_entry_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,    // no pulse seen yet
    ST_PULSE,   // reset pin high, waiting for it to fall
    ST_GAP,     // settling after pulse, clock edges ignored
    ST_KEY,     // shifting key bits
    ST_ARMED,   // full matching key, waiting for rise
    ST_REJECT,  // full non-matching key
    ST_SETTLE,  // mode held, data still blanked
    ST_OPEN     // mode held, data forwarded
  } entry_state_e;
endpackage

// File: rtl/pgm_entry_sync.sv
module pgm_entry_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= d_async;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/pgm_entry_timer.sv
module pgm_entry_timer #(
  parameter int unsigned MAX_COUNT = 24,
  localparam int unsigned CW = $clog2(MAX_COUNT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/pgm_entry_keyshift.sv
module pgm_entry_keyshift #(
  parameter int unsigned       KEY_W     = 32,
  parameter logic [KEY_W-1:0]  KEY_VALUE = 32'h4D434851,
  localparam int unsigned      NW        = $clog2(KEY_W + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic shift_en,
  input  logic bit_in,
  output logic full,
  output logic match
);
  logic [KEY_W-1:0] sr_q;
  logic [NW-1:0]    n_q;

  assign full  = (n_q == NW'(KEY_W));
  assign match = full && (sr_q == KEY_VALUE);

  // first bit received ends up in the top position
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
      n_q  <= '0;
    end else if (clr) begin
      sr_q <= '0;
      n_q  <= '0;
    end else if (shift_en && !full) begin
      sr_q <= {sr_q[KEY_W-2:0], bit_in};
      n_q  <= n_q + 1'b1;
    end
  end
endmodule

// File: rtl/pgm_entry_detect.sv
module pgm_entry_detect #(
  parameter int unsigned      KEY_W       = 32,
  parameter logic [KEY_W-1:0] KEY_VALUE   = 32'h4D434851,
  parameter int unsigned      ENTRY_GAP   = 16,
  parameter int unsigned      EXIT_GAP    = 24,
  parameter int unsigned      SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_pin,
  input  logic ser_clk,
  input  logic ser_dat,
  output logic mode_active,
  output logic io_hiz,
  output logic data_open,
  output logic rx_valid,
  output logic rx_bit
);
  import pgm_entry_pkg::*;

  localparam int unsigned GAP_MAX = (ENTRY_GAP > EXIT_GAP) ? ENTRY_GAP : EXIT_GAP;
  localparam int unsigned TW      = $clog2(GAP_MAX + 1);

  logic [2:0] pins_s;
  logic hold_s, sclk_s, dat_s;
  logic hold_q, sclk_q;
  logic hold_rise, hold_fall, sclk_rise;

  pgm_entry_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d_async({hold_pin, ser_clk, ser_dat}),
    .q_sync(pins_s)
  );
  assign {hold_s, sclk_s, dat_s} = pins_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
      sclk_q <= 1'b0;
    end else begin
      hold_q <= hold_s;
      sclk_q <= sclk_s;
    end
  end
  assign hold_rise = hold_s & ~hold_q;
  assign hold_fall = ~hold_s & hold_q;
  assign sclk_rise = sclk_s & ~sclk_q;

  entry_state_e state_q, state_d;
  logic          tmr_load, tmr_expired;
  logic [TW-1:0] tmr_val;
  logic          key_clr, key_shift, key_full, key_match;

  pgm_entry_timer #(.MAX_COUNT(GAP_MAX)) u_timer (
    .clk(clk), .rst_n(rst_n),
    .load(tmr_load), .load_val(tmr_val),
    .expired(tmr_expired)
  );

  pgm_entry_keyshift #(.KEY_W(KEY_W), .KEY_VALUE(KEY_VALUE)) u_key (
    .clk(clk), .rst_n(rst_n),
    .clr(key_clr), .shift_en(key_shift), .bit_in(dat_s),
    .full(key_full), .match(key_match)
  );

  assign key_clr   = (state_q == ST_IDLE) || (state_q == ST_PULSE);
  assign key_shift = (state_q == ST_KEY) && sclk_rise;

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = TW'(ENTRY_GAP);
    unique case (state_q)
      ST_IDLE:   if (hold_rise) state_d = ST_PULSE;
      ST_PULSE:  if (hold_fall) begin
                   state_d  = ST_GAP;
                   tmr_load = 1'b1;
                   tmr_val  = TW'(ENTRY_GAP);
                 end
      ST_GAP:    if (hold_rise)        state_d = ST_PULSE;
                 else if (tmr_expired) state_d = ST_KEY;
      ST_KEY:    if (hold_rise)        state_d = ST_PULSE;
                 else if (key_full)    state_d = key_match ? ST_ARMED : ST_REJECT;
      ST_ARMED:  if (hold_rise) begin
                   state_d  = ST_SETTLE;
                   tmr_load = 1'b1;
                   tmr_val  = TW'(EXIT_GAP);
                 end
      ST_REJECT: if (hold_rise) state_d = ST_PULSE;
      ST_SETTLE: if (hold_fall)        state_d = ST_IDLE;
                 else if (tmr_expired) state_d = ST_OPEN;
      ST_OPEN:   if (hold_fall) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid <= 1'b0;
      rx_bit   <= 1'b0;
    end else begin
      rx_valid <= (state_q == ST_OPEN) && sclk_rise && !hold_fall;
      if ((state_q == ST_OPEN) && sclk_rise) rx_bit <= dat_s;
    end
  end

  assign mode_active = (state_q == ST_SETTLE) || (state_q == ST_OPEN);
  assign io_hiz      = (state_q == ST_SETTLE) || (state_q == ST_OPEN);
  assign data_open   = (state_q == ST_OPEN);
endmodule

// File: rtl/pgm_entry_detect_chk.sv
module pgm_entry_detect_chk (
  input logic clk,
  input logic rst_n,
  input logic hold_s,
  input logic hold_fall,
  input logic key_full,
  input logic key_match,
  input logic mode_active,
  input logic io_hiz,
  input logic data_open,
  input logic rx_valid
);
  // R10: a falling reset pin ends the mode on the next cycle
  a_r10_fall_drops_mode: assert property (@(posedge clk) disable iff (!rst_n)
    hold_fall |=> (!mode_active && !io_hiz));

  // R10: with the reset pin low the mode cannot be held
  a_r10_low_pin_no_mode: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_s |=> !mode_active);

  // R2 / R4: entry only from a complete, matching key
  a_r2_entry_needs_key: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode_active) |-> $past(key_full && key_match));

  // R8: no forwarded bit right after entry
  a_r8_blank_after_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode_active) |=> !rx_valid);

  // R9: strobes only come from the open phase
  a_r9_valid_from_open: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(data_open));
endmodule

bind pgm_entry_detect pgm_entry_detect_chk u_chk (
  .clk(clk), .rst_n(rst_n), .hold_s(hold_s), .hold_fall(hold_fall),
  .key_full(key_full), .key_match(key_match),
  .mode_active(mode_active), .io_hiz(io_hiz),
  .data_open(data_open), .rx_valid(rx_valid)
);

// File: tb/pgm_entry_detect_test.sv
module pgm_entry_detect_test;
  localparam int unsigned ENTRY_GAP = 16;
  localparam int unsigned EXIT_GAP  = 24;
  localparam logic [31:0] KEY       = 32'h4D434851;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hold_pin = 1'b0, ser_clk = 1'b0, ser_dat = 1'b0;
  logic mode_active, io_hiz, data_open, rx_valid, rx_bit;

  always #2.5 clk = ~clk;

  pgm_entry_detect #(.ENTRY_GAP(ENTRY_GAP), .EXIT_GAP(EXIT_GAP)) uut (
    .clk(clk), .rst_n(rst_n), .hold_pin(hold_pin), .ser_clk(ser_clk),
    .ser_dat(ser_dat), .mode_active(mode_active), .io_hiz(io_hiz),
    .data_open(data_open), .rx_valid(rx_valid), .rx_bit(rx_bit)
  );

  int vectors = 0;
  int errors  = 0;
  int cyc     = 0;
  logic exp_q[$];
  string phase_req = "R1";

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    ser_dat = b;
    idle(3);
    ser_clk = 1'b1;
    idle(3);
    ser_clk = 1'b0;
    idle(3);
  endtask

  // scoreboard driver: expected item queued before the edge
  task automatic send_expect(input logic b);
    exp_q.push_back(b);
    send_bit(b);
  endtask

  task automatic send_word(input logic [31:0] w, input int n, input bit msb_first);
    for (int i = 0; i < n; i++)
      send_bit(msb_first ? w[31-i] : w[i]);
  endtask

  task automatic give_pulse();
    hold_pin = 1'b1;
    idle(6);
    hold_pin = 1'b0;
    idle(ENTRY_GAP + 10);
  endtask

  // monitor: pops the scoreboard on every strobe
  always @(negedge clk) begin
    if (rst_n && rx_valid) begin
      vectors++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL %s unexpected strobe actual=%0b expected=none", phase_req, rx_bit);
      end else begin
        logic e;
        e = exp_q.pop_front();
        if (rx_bit !== e) begin
          errors++;
          $display("FAIL R9 bit order actual=%0b expected=%0b", rx_bit, e);
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=finish", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    idle(4);
    rst_n = 1'b1;
    idle(2);
    // R1 reset state
    check(mode_active == 0, "R1 mode", mode_active, 0);
    check(io_hiz == 0,      "R1 hiz",  io_hiz, 0);
    check(data_open == 0 && rx_valid == 0, "R1 data", data_open, 0);

    // R5: key with no preceding pulse is not taken
    send_word(KEY, 32, 1'b1);
    hold_pin = 1'b1;
    idle(10);
    check(mode_active == 0, "R5 no pulse", mode_active, 0);

    // R6: that high period ends as a pulse; an edge inside the gap is ignored
    hold_pin = 1'b0;
    send_bit(1'b1);
    idle(ENTRY_GAP + 10);
    send_word(KEY, 32, 1'b1);
    hold_pin = 1'b1;
    // R8: edges during the exit blanking produce nothing
    phase_req = "R8";
    send_bit(1'b1);
    send_bit(1'b0);
    idle(EXIT_GAP + 6);
    check(mode_active == 1, "R2 mode after good key (R6 gap edge)", mode_active, 1);
    check(io_hiz == 1,      "R2 hiz", io_hiz, 1);
    check(data_open == 1,   "R9 open after blanking", data_open, 1);

    // R9: forwarded bit stream
    phase_req = "R9";
    for (int i = 0; i < 8; i++) send_expect(8'b1011_0010 >> (7 - i) & 1'b1);
    idle(6);
    check(exp_q.size() == 0, "R9 all bits seen", exp_q.size(), 0);

    // R10: pin fall ends the mode
    hold_pin = 1'b0;
    idle(8);
    check(mode_active == 0, "R10 mode dropped", mode_active, 0);
    check(io_hiz == 0,      "R10 hiz dropped", io_hiz, 0);
    check(data_open == 0,   "R10 data closed", data_open, 0);
    phase_req = "R10";
    send_bit(1'b1);
    idle(5);

    // R4: wrong key
    give_pulse();
    send_word(KEY ^ 32'h1, 32, 1'b1);
    hold_pin = 1'b1;
    idle(10);
    check(mode_active == 0, "R4 wrong key", mode_active, 0);
    hold_pin = 1'b0;
    idle(ENTRY_GAP + 10);

    // R3: key sent LSB first
    send_word(KEY, 32, 1'b0);
    hold_pin = 1'b1;
    idle(10);
    check(mode_active == 0, "R3 lsb-first key", mode_active, 0);
    hold_pin = 1'b0;
    idle(ENTRY_GAP + 10);

    // R7: early rise refuses and clears the key
    send_word(KEY, 16, 1'b1);
    hold_pin = 1'b1;
    idle(10);
    check(mode_active == 0, "R7 early rise refused", mode_active, 0);
    hold_pin = 1'b0;
    idle(ENTRY_GAP + 10);
    send_word(KEY, 32, 1'b1);
    hold_pin = 1'b1;
    idle(EXIT_GAP + 10);
    check(mode_active == 1, "R7 clean retry enters", mode_active, 1);
    hold_pin = 1'b0;
    idle(8);

    // R11: extra edges after the key are ignored
    give_pulse();
    send_word(KEY, 32, 1'b1);
    send_bit(1'b0);
    send_bit(1'b1);
    send_bit(1'b1);
    hold_pin = 1'b1;
    idle(EXIT_GAP + 10);
    check(mode_active == 1, "R11 extra bits ignored", mode_active, 1);
    phase_req = "R9";
    send_expect(1'b0);
    send_expect(1'b1);
    send_expect(1'b0);
    send_expect(1'b1);
    idle(6);
    check(exp_q.size() == 0, "R9 second stream", exp_q.size(), 0);
    hold_pin = 1'b0;
    idle(8);
    check(mode_active == 0, "R10 final drop", mode_active, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule